// File: doc/BRIEF.md
# Torus Systolic Matrix Multiplier

This block computes the product C = A × B of two square matrices of signed integers. The matrices are DIM × DIM, with DIM = 4 by default. The work is spread over a DIM × DIM grid of processing cells. Each cell owns one element of A, one element of B and one accumulator for C.

Software writes the operands one element at a time through an addressed write port. It then pulses `start`. The block first skews the operands in place: row i of A turns left by i places and column j of B turns up by j places. Both moves use the same single-step neighbour paths that the compute phase uses later. The block then runs DIM rounds. In each round every cell adds the product of its current A and B to its accumulator. In the same clock edge, all A values move one cell left and all B values move one cell up, wrapping at the grid edge.

When the last round ends, `done` pulses for one cycle. Each result element can then be read combinationally at the same address used to write operands. After a run the operand registers are left rotated, so a new product needs fresh operands.

Top module: `torus_matmul`

## Requirements
- R1: While reset is active and directly after it, `busy` and `done` are 0 and `rd_data` is 0 at every address.
- R2: With `busy` low, a cycle with `wr_en` high stores `wr_data` as element (row, col) of A when `wr_sel` = 0, or of B when `wr_sel` = 1. The address is `addr` = row × DIM + col.
- R3: After a run, `rd_data` at address row × DIM + col equals the two's-complement sum over k of A[row][k] × B[k][col].
- R4: `done` is high for exactly one cycle. It rises 2·DIM clock edges after the edge that samples `start`, counting that edge as the first.
- R5: `busy` rises only in the cycle after an accepted `start`. It stays high for 2·DIM − 1 cycles and is low whenever `done` is high.
- R6: A `start` that arrives while `busy` is high is ignored. The run in progress keeps its timing and its result.
- R7: A write that arrives while `busy` is high is ignored and does not change the result.
- R8: Between `done` and the next accepted `start`, the results stay unchanged, even while new operands are written.
- R9: An accepted `start` clears every accumulator, so a repeated run gives the product again and not a sum of runs.
- R10: Results are 2·OPW + log2(DIM) bits wide, so extreme operands (all −128, or 127 against −128) give exact values with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one operand element |
| wr_sel | input | 1 | Operand select: 0 = A, 1 = B |
| addr | input | AW | Element address row × DIM + col, used for writes and for result reads |
| wr_data | input | OPW | Signed operand element |
| start | input | 1 | Begin a multiplication when idle |
| busy | output | 1 | Alignment or compute in progress |
| done | output | 1 | One-cycle pulse at the end of the last round |
| rd_data | output | CW | Signed result element at `addr` |

## Verification
The hardest cases to reach from the ports are inputs that arrive in the middle of a run. A stray `start` or a write during alignment must be ignored, and the only visible effect of failing to ignore them would be a wrong result or a shifted `done`. The bench counts edges from the accepted `start` and injects both a second `start` and a write to A in the same mid-run cycle. It then checks that `done` appears in its exact cycle and that all sixteen results still match the product computed from the original operands. Accumulator clearing is reached by running the same operands twice. Result retention is checked by writing fresh operands after `done` and reading every result again.

// File: rtl/torus_pkg.sv
// Shared types for the torus matrix multiplier.
// Assumes: imported by the sequencer and the top module.
package torus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_MAC   = 2'd2
    } seq_state_t;

    localparam logic SEL_A = 1'b0;
    localparam logic SEL_B = 1'b1;
endpackage

// File: rtl/torus_seq.sv
// Run sequencer: accepts start when idle, then runs DIM-1 alignment steps
// followed by DIM multiply-accumulate rounds.
// Assumes: DIM >= 1. rot[k] enables a one-place rotation for row k of A and
// for column k of B, since both follow the same rule.
module torus_seq
    import torus_pkg::*;
#(
    parameter int DIM = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic           clr_acc,
    output logic           mac_en,
    output logic [DIM-1:0] rot
);
    localparam int SW         = $clog2(DIM + 1);
    localparam int ALIGN_LAST = (DIM > 1) ? DIM - 2 : 0;
    localparam int MAC_LAST   = DIM - 1;

    seq_state_t    state_q;
    logic [SW-1:0] step_q;
    logic          done_q;

    // State, step counter and the registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        step_q  <= '0;
                        state_q <= (DIM > 1) ? ST_ALIGN : ST_MAC;
                    end
                end
                ST_ALIGN: begin
                    if (step_q == SW'(ALIGN_LAST)) begin
                        step_q  <= '0;
                        state_q <= ST_MAC;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_MAC: begin
                    if (step_q == SW'(MAC_LAST)) begin
                        step_q  <= '0;
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Per-lane rotation enable: a lane with index g rotates during alignment
    // steps 0..g-1, and every lane rotates in each compute round.
    for (genvar g = 0; g < DIM; g++) begin : g_rot
        assign rot[g] = (state_q == ST_MAC) ||
                        ((state_q == ST_ALIGN) && (SW'(g) > step_q));
    end

    // Decoded controls for the cell grid.
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign clr_acc = (state_q == ST_IDLE) && start;
    assign mac_en  = (state_q == ST_MAC);
endmodule

// File: rtl/torus_pe.sv
// One grid cell: holds an A element, a B element and a C accumulator.
// Assumes: a write has priority over a rotation, and a clear has priority
// over accumulation. The product uses the values held before the edge.
module torus_pe #(
    parameter int OPW = 8,
    parameter int CW  = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  mac_en,
    input  logic                  ld_a,
    input  logic                  ld_b,
    input  logic [OPW-1:0]        ld_data,
    input  logic                  rot_a,
    input  logic signed [OPW-1:0] a_nb,
    input  logic                  rot_b,
    input  logic signed [OPW-1:0] b_nb,
    output logic signed [OPW-1:0] a_q,
    output logic signed [OPW-1:0] b_q,
    output logic signed [CW-1:0]  c_q
);
    logic signed [2*OPW-1:0] prod;

    // Full-precision signed product of the held operands.
    assign prod = a_q * b_q;

    // A element: written from the port, or taken from the right-hand neighbour.
    always_ff @(posedge clk) begin
        if (!rst_n)     a_q <= '0;
        else if (ld_a)  a_q <= ld_data;
        else if (rot_a) a_q <= a_nb;
    end

    // B element: written from the port, or taken from the neighbour below.
    always_ff @(posedge clk) begin
        if (!rst_n)     b_q <= '0;
        else if (ld_b)  b_q <= ld_data;
        else if (rot_b) b_q <= b_nb;
    end

    // Accumulator: cleared by an accepted start, grows once per round.
    always_ff @(posedge clk) begin
        if (!rst_n)      c_q <= '0;
        else if (clr)    c_q <= '0;
        else if (mac_en) c_q <= c_q + CW'(prod);
    end
endmodule

// File: rtl/torus_matmul.sv
// Top of the torus matrix multiplier: a DIM x DIM grid of cells on
// wraparound neighbour links, an addressed operand write port and a
// combinational result read.
// Assumes: addr = row*DIM + col. Writes are accepted only while idle.
module torus_matmul
    import torus_pkg::*;
#(
    parameter int DIM = 4,
    parameter int OPW = 8,
    localparam int AW = (DIM > 1) ? $clog2(DIM * DIM) : 1,
    localparam int CW = 2 * OPW + $clog2(DIM)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_sel,
    input  logic [AW-1:0]  addr,
    input  logic [OPW-1:0] wr_data,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic [CW-1:0]  rd_data
);
    localparam int NCELL = DIM * DIM;

    logic signed [OPW-1:0] a_w [DIM][DIM];
    logic signed [OPW-1:0] b_w [DIM][DIM];
    logic signed [CW-1:0]  c_w [DIM][DIM];
    logic [NCELL*CW-1:0]   c_all;
    logic [DIM-1:0]        rot;
    logic                  clr_acc;
    logic                  mac_en;
    logic                  wr_ok;

    // Writes land only while no run is in progress.
    assign wr_ok = wr_en && !busy;

    torus_seq #(.DIM(DIM)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .clr_acc (clr_acc),
        .mac_en  (mac_en),
        .rot     (rot)
    );

    for (genvar i = 0; i < DIM; i++) begin : g_row
        for (genvar j = 0; j < DIM; j++) begin : g_col
            localparam int IDX = i * DIM + j;
            logic ld_a;
            logic ld_b;

            // Address decode for this cell's two operand registers.
            assign ld_a = wr_ok && (wr_sel == SEL_A) && (addr == AW'(IDX));
            assign ld_b = wr_ok && (wr_sel == SEL_B) && (addr == AW'(IDX));

            torus_pe #(.OPW(OPW), .CW(CW)) pe_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr_acc),
                .mac_en  (mac_en),
                .ld_a    (ld_a),
                .ld_b    (ld_b),
                .ld_data (wr_data),
                .rot_a   (rot[i]),
                .a_nb    (a_w[i][(j + 1) % DIM]),
                .rot_b   (rot[j]),
                .b_nb    (b_w[(i + 1) % DIM][j]),
                .a_q     (a_w[i][j]),
                .b_q     (b_w[i][j]),
                .c_q     (c_w[i][j])
            );

            // Flattened result vector, one slice per cell.
            assign c_all[IDX*CW +: CW] = c_w[i][j];
        end
    end

    // Result read: select the addressed accumulator (zero when out of range).
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NCELL; k++) begin
            if (addr == AW'(k)) rd_data = c_all[k*CW +: CW];
        end
    end
endmodule

// File: rtl/torus_matmul_chk.sv
// Protocol checker for torus_matmul, attached by bind.
// Assumes: the same DIM and CW as the bound instance.
module torus_matmul_chk #(
    parameter int DIM = 4,
    parameter int CW  = 18
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic [DIM*DIM*CW-1:0] c_all
);
    localparam int LW = $clog2(2 * DIM + 1);

    logic [LW-1:0] run_len;

    // Count busy cycles since the run began.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == LW'(2 * DIM - 1)));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!busy) && !$past(start)) |-> $stable(c_all));
endmodule

bind torus_matmul torus_matmul_chk #(.DIM(DIM), .CW(CW)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .c_all (c_all)
);

// File: tb/torus_matmul_tb_top.sv
`timescale 1ns/1ps
// Bench for torus_matmul: a vector table walked by one loop, then directed
// tests for mid-run inputs, result retention, repeat runs and reset.
module torus_matmul_tb_top;
    localparam int DIM = 4;
    localparam int OPW = 8;
    localparam int AW  = 4;
    localparam int CW  = 18;
    localparam int NV  = 6;
    // Operand seed pairs {A, B}: 1000 = all -128, 1001 = all 127,
    // 2000 = identity, any other value = mixed pattern.
    localparam int VEC_A [NV] = '{2000, 11, 1000, 1001, 3, 42};
    localparam int VEC_B [NV] = '{7, 2000, 1000, 1000, 9, 77};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           wr_sel = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [OPW-1:0] wr_data = '0;
    logic           start = 1'b0;
    logic           busy;
    logic           done;
    logic [CW-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    int mat_a [DIM*DIM];
    int mat_b [DIM*DIM];
    int snap  [DIM*DIM];

    always #10 clk = ~clk;

    torus_matmul #(.DIM(DIM), .OPW(OPW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .addr(addr), .wr_data(wr_data), .start(start),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gen_elem(input int seed, input int idx);
        if (seed == 1000) return -128;
        if (seed == 1001) return 127;
        if (seed == 2000) return (idx % 5 == 0) ? 1 : 0;
        return ((seed * 37 + idx * 113 + idx * idx * 7) % 256) - 128;
    endfunction

    task automatic write_elem(input logic sel, input int idx, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; addr = AW'(idx); wr_data = OPW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_mats(input int sa, input int sb);
        for (int k = 0; k < DIM*DIM; k++) begin
            mat_a[k] = gen_elem(sa, k);
            write_elem(1'b0, k, mat_a[k]);
        end
        for (int k = 0; k < DIM*DIM; k++) begin
            mat_b[k] = gen_elem(sb, k);
            write_elem(1'b1, k, mat_b[k]);
        end
    endtask

    function automatic int read_at(input int idx);
        int v;
        v = $signed(rd_data);
        return v;
    endfunction

    // Start a run, optionally poking start and a write to A in cycle 3,
    // and check busy/done cycle by cycle.
    task automatic run(input bit poke, input string tag);
        int bad;
        bad = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (!(busy && !done)) bad++;
        for (int n = 2; n <= 2*DIM; n++) begin
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
            if (n < 2*DIM) begin
                if (!(busy && !done)) bad++;
            end else begin
                check(done && !busy, {tag, " R4 done at edge 2*DIM"}, int'(done), 1);
            end
            if (poke && n == 3) begin
                start = 1'b1;
                wr_en = 1'b1; wr_sel = 1'b0; addr = '0; wr_data = 8'd99;
            end
        end
        check(bad == 0, {tag, " R5 busy window"}, bad, 0);
        @(negedge clk);
        check(!done && !busy, {tag, " R4 single pulse"}, int'(done), 0);
    endtask

    task automatic check_results(input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < DIM; i++) begin
            for (int j = 0; j < DIM; j++) begin
                int exp;
                int got;
                exp = 0;
                for (int k = 0; k < DIM; k++) exp += mat_a[i*DIM+k] * mat_b[k*DIM+j];
                @(negedge clk); addr = AW'(i*DIM+j); #2;
                got = read_at(i*DIM+j);
                if (got != exp) begin
                    bad++;
                    $display("FAIL %s R3 cell %0d actual=%0d expected=%0d", tag, i*DIM+j, got, exp);
                end
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic check_all_zero(input string tag);
        int nz;
        nz = 0;
        for (int k = 0; k < DIM*DIM; k++) begin
            @(negedge clk); addr = AW'(k); #2;
            if (rd_data != '0) nz++;
        end
        check(nz == 0 && !busy && !done, {tag, " R1 reset state"}, nz, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1 outputs in reset", int'(busy), 0);
        rst_n = 1'b1;
        check_all_zero("after reset");

        // Table walk: R2, R3, R10 under several operand patterns.
        for (int v = 0; v < NV; v++) begin
            load_mats(VEC_A[v], VEC_B[v]);
            run(1'b0, "table");
            check_results("R2 R3 R10 table");
        end

        // R9: repeat run, result must not double.
        load_mats(3, 9);
        run(1'b0, "first");
        load_mats(3, 9);
        run(1'b0, "repeat");
        check_results("R9 repeat");

        // R6 and R7: start and write poked mid-run.
        load_mats(42, 77);
        run(1'b1, "R6 R7 poke");
        check_results("R6 R7 ignored");

        // R8: results hold while new operands are written after done.
        for (int k = 0; k < DIM*DIM; k++) begin
            @(negedge clk); addr = AW'(k); #2;
            snap[k] = $signed(rd_data);
        end
        write_elem(1'b0, 0, 55);
        write_elem(1'b1, 5, -3);
        repeat (10) @(negedge clk);
        begin
            int moved;
            moved = 0;
            for (int k = 0; k < DIM*DIM; k++) begin
                int got;
                @(negedge clk); addr = AW'(k); #2;
                got = $signed(rd_data);
                if (got != snap[k]) moved++;
            end
            check(moved == 0, "R8 results held", moved, 0);
        end

        // R1: reset in the middle of a run.
        load_mats(11, 2000);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !done, "R1 mid-run reset", int'(busy), 0);
        rst_n = 1'b1;
        check_all_zero("mid-run reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule